// File: doc/BRIEF.md
# LED Matrix Paged Register Bank

This block is the register file behind an LED matrix controller. A host writes to it through a plain byte-write interface. A start strobe opens a burst. The first byte after it is the register address, and every further byte is data. The address pointer advances by one after each data byte, so a whole row of duty values can go in as one burst.

The register space is split into four pages: LED on/off control, PWM duty, breath settings and function/configuration. Only one page at a time receives the page-local writes. Changing the page is a two-step action. A key byte written to the key register arms a one-shot unlock, and the next write to the page-select register spends that unlock. A page-select write that arrives while the block is locked is dropped and raises a sticky error flag. The key register, the page-select register and the two interrupt registers can be written whatever page is active.

The function page drives the configuration outputs: sync mode, PWM frequency select, the run bit that releases shutdown, global current, and the row and column resistor selects. A write to its reset register clears the contents of every page. Each page has its own combinational read port.

Top module: `ledbank_top`

## Requirements
- R1: During and after a synchronous reset the block is locked, the selected page is 0 (on/off), the error flag is 0, every configuration output is 0 and every page read port returns 0x00.
- R2: After the address byte of a burst, each data byte is written at the current pointer and the pointer then advances by one. A burst at 0x10 carrying N bytes fills 0x10 through 0x10+N-1 of the active page.
- R3: Writing 0xC5 to address 0xFE unlocks the block. The next write to 0xFD whose value is 0 to 3 selects that page (0 on/off, 1 PWM, 2 breath, 3 function), and the block re-locks after that write.
- R4: A write to 0xFD while locked leaves the selected page unchanged and sets a lock-error flag, which stays at 1 until reset.
- R5: Writing any value other than 0xC5 to 0xFE leaves the block locked, and a later write to 0xFD is then refused.
- R6: A write to 0xFD while unlocked whose value is 4 or more keeps the current page and still re-locks the block.
- R7: Page 1 holds 192 bytes at 0x00–0xBF. Page 0 holds 24 bytes at 0x00–0x17, and page 2 holds 192 bytes. Writes to a page change only the page that is selected.
- R8: On page 3, address 0x00 holds the configuration byte. Bits 7:6 drive sync_mode, bits 5:3 drive pwm_freq and bit 0 drives run_en. Addresses 0x01, 0x0F and 0x10 drive global_current, row_pullup and col_pulldown.
- R9: Addresses 0xF0 (interrupt mask) and 0xF1 (interrupt status) are written on any page. A burst at 0xF0 with two bytes sets both.
- R10: Any data write to address 0x11 on page 3 clears all three data pages and all function registers, so run_en goes to 0. The selected page, the lock state and the interrupt registers keep their values.
- R11: A write to an address at or beyond a page's size is ignored, and a read of such an address returns 0x00. On page 3 only 0x00, 0x01, 0x0F and 0x10 read back.
- R12: A start strobe in the middle of a burst discards the old pointer. A start strobe in the same cycle as a valid byte takes that byte as the address, not as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Opens a new burst; the next (or same-cycle) byte is the address |
| bus_valid | input | 1 | A byte is present on bus_data this cycle |
| bus_data | input | 8 | Address or data byte |
| rd_addr | input | 4x8 | Read address for each page, index = page number |
| rd_data | output | 4x8 | Read data for each page, 0x00 outside the page |
| cur_page | output | 2 | Selected page |
| unlocked | output | 1 | One-shot unlock is armed |
| lock_err | output | 1 | Sticky: a page-select write was refused while locked |
| sync_mode | output | 2 | Configuration bits 7:6 |
| pwm_freq | output | 3 | Configuration bits 5:3 |
| run_en | output | 1 | Configuration bit 0, shutdown released |
| global_current | output | 8 | Function page 0x01 |
| row_pullup | output | 8 | Function page 0x0F |
| col_pulldown | output | 8 | Function page 0x10 |
| irq_mask | output | 8 | Register 0xF0 |
| irq_status | output | 8 | Register 0xF1 |

## Verification
The assertions assume that bus_start and bus_valid are clean 0/1 levels that change only away from the rising edge. They also assume that a data write is the only thing that can change the page or the unlock state. The stimulus drives every input on the falling edge, so each byte is held for exactly one rising edge. Every burst opens with a start strobe, and the pointer is never walked past 0xFF. The same-cycle start-and-byte case is driven on purpose, with the same one-edge timing as the other bursts.

// File: rtl/ledbank_pkg.sv
package ledbank_pkg;

    localparam int NUM_PAGES = 4;
    localparam int BYTE_W    = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Page-independent registers
    localparam byte_t ADR_KEY     = 8'hFE;
    localparam byte_t ADR_PAGESEL = 8'hFD;
    localparam byte_t ADR_IRQMASK = 8'hF0;
    localparam byte_t ADR_IRQSTAT = 8'hF1;
    localparam byte_t UNLOCK_KEY  = 8'hC5;

    // Function page offsets
    localparam byte_t FN_CFG   = 8'h00;
    localparam byte_t FN_GCC   = 8'h01;
    localparam byte_t FN_ROWPU = 8'h0F;
    localparam byte_t FN_COLPD = 8'h10;
    localparam byte_t FN_CLEAR = 8'h11;

    typedef enum logic [1:0] {
        PG_ONOFF  = 2'd0,
        PG_PWM    = 2'd1,
        PG_BREATH = 2'd2,
        PG_FUNC   = 2'd3
    } page_e;

    typedef struct packed {
        logic  en;
        byte_t addr;
        byte_t data;
    } wr_t;

    typedef struct packed {
        logic [1:0] sync;
        logic [2:0] pfreq;
        logic       run;
    } cfg_fields_t;

    function automatic cfg_fields_t decode_cfg(input byte_t c);
        cfg_fields_t f;
        f.sync  = c[7:6];
        f.pfreq = c[5:3];
        f.run   = c[0];
        return f;
    endfunction

    function automatic logic is_global(input byte_t a);
        return (a == ADR_KEY) || (a == ADR_PAGESEL) ||
               (a == ADR_IRQMASK) || (a == ADR_IRQSTAT);
    endfunction

    function automatic logic page_ok(input byte_t v);
        return int'(v) < NUM_PAGES;
    endfunction

    function automatic int depth_of(input int g, input int d0, input int d1, input int d2);
        return (g == 0) ? d0 : ((g == 1) ? d1 : d2);
    endfunction

endpackage

// File: rtl/ledbank_burst.sv
module ledbank_burst
    import ledbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  valid,
    input  byte_t data,
    output wr_t   wr
);

    logic  addr_held;
    byte_t ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_held <= 1'b0;
            ptr       <= '0;
        end else if (start) begin
            // a byte arriving with the strobe is the address
            addr_held <= valid;
            if (valid)
                ptr <= data;
        end else if (valid) begin
            if (!addr_held) begin
                ptr       <= data;
                addr_held <= 1'b1;
            end else begin
                ptr <= ptr + 8'd1;
            end
        end
    end

    always_comb begin
        wr.en   = valid && !start && addr_held;
        wr.addr = ptr;
        wr.data = data;
    end

endmodule

// File: rtl/ledbank_lock.sv
module ledbank_lock
    import ledbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wr_t   wr,
    output page_e page,
    output logic  armed,
    output logic  err
);

    logic hit_key;
    logic hit_sel;

    assign hit_key = wr.en && (wr.addr == ADR_KEY);
    assign hit_sel = wr.en && (wr.addr == ADR_PAGESEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            page  <= PG_ONOFF;
            armed <= 1'b0;
            err   <= 1'b0;
        end else if (hit_key) begin
            armed <= (wr.data == UNLOCK_KEY);
        end else if (hit_sel) begin
            if (armed) begin
                armed <= 1'b0;
                if (page_ok(wr.data))
                    page <= page_e'(wr.data[1:0]);
            end else begin
                err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ledbank_page_store.sv
module ledbank_page_store
    import ledbank_pkg::*;
#(
    parameter int DEPTH = 24
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  we,
    input  byte_t waddr,
    input  byte_t wdata,
    input  byte_t raddr,
    output byte_t rdata
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    byte_t mem [DEPTH];
    logic  w_in;
    logic  r_in;

    assign w_in = int'(waddr) < DEPTH;
    assign r_in = int'(raddr) < DEPTH;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we && w_in) begin
            mem[waddr[IDX_W-1:0]] <= wdata;
        end
    end

    assign rdata = r_in ? mem[raddr[IDX_W-1:0]] : '0;

endmodule

// File: rtl/ledbank_func.sv
module ledbank_func
    import ledbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        we,
    input  byte_t       waddr,
    input  byte_t       wdata,
    input  byte_t       raddr,
    output byte_t       rdata,
    output cfg_fields_t cfg,
    output byte_t       gcc,
    output byte_t       rowpu,
    output byte_t       colpd
);

    byte_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cfg_q <= '0;
            gcc   <= '0;
            rowpu <= '0;
            colpd <= '0;
        end else if (we) begin
            case (waddr)
                FN_CFG:   cfg_q <= wdata;
                FN_GCC:   gcc   <= wdata;
                FN_ROWPU: rowpu <= wdata;
                FN_COLPD: colpd <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (raddr)
            FN_CFG:   rdata = cfg_q;
            FN_GCC:   rdata = gcc;
            FN_ROWPU: rdata = rowpu;
            FN_COLPD: rdata = colpd;
            default:  rdata = '0;
        endcase
    end

    assign cfg = decode_cfg(cfg_q);

endmodule

// File: rtl/ledbank_top.sv
module ledbank_top
    import ledbank_pkg::*;
#(
    parameter int ONOFF_BYTES  = 24,
    parameter int PWM_BYTES    = 192,
    parameter int BREATH_BYTES = 192
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_start,
    input  logic                          bus_valid,
    input  logic [7:0]                    bus_data,
    input  logic [NUM_PAGES-1:0][7:0]     rd_addr,
    output logic [NUM_PAGES-1:0][7:0]     rd_data,
    output logic [1:0]                    cur_page,
    output logic                          unlocked,
    output logic                          lock_err,
    output logic [1:0]                    sync_mode,
    output logic [2:0]                    pwm_freq,
    output logic                          run_en,
    output logic [7:0]                    global_current,
    output logic [7:0]                    row_pullup,
    output logic [7:0]                    col_pulldown,
    output logic [7:0]                    irq_mask,
    output logic [7:0]                    irq_status
);

    localparam int DATA_PAGES = NUM_PAGES - 1;

    wr_t         wr;
    page_e       pg_sel;
    logic [1:0]  pg_raw;
    logic        pg_we;
    logic        cfg_clr;
    cfg_fields_t cfg;

    ledbank_burst u_burst (
        .clk   (clk),
        .rst   (rst),
        .start (bus_start),
        .valid (bus_valid),
        .data  (bus_data),
        .wr    (wr)
    );

    ledbank_lock u_lock (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .page  (pg_sel),
        .armed (unlocked),
        .err   (lock_err)
    );

    assign pg_raw   = pg_sel;
    assign cur_page = pg_raw;

    // page-local write: anything not aimed at a global register
    assign pg_we   = wr.en && !is_global(wr.addr);
    assign cfg_clr = pg_we && (pg_sel == PG_FUNC) && (wr.addr == FN_CLEAR);

    for (genvar g = 0; g < DATA_PAGES; g++) begin : g_page
        ledbank_page_store #(
            .DEPTH (depth_of(g, ONOFF_BYTES, PWM_BYTES, BREATH_BYTES))
        ) u_store (
            .clk   (clk),
            .rst   (rst),
            .clr   (cfg_clr),
            .we    (pg_we && (pg_raw == 2'(g))),
            .waddr (wr.addr),
            .wdata (wr.data),
            .raddr (rd_addr[g]),
            .rdata (rd_data[g])
        );
    end

    ledbank_func u_func (
        .clk   (clk),
        .rst   (rst),
        .clr   (cfg_clr),
        .we    (pg_we && (pg_sel == PG_FUNC)),
        .waddr (wr.addr),
        .wdata (wr.data),
        .raddr (rd_addr[DATA_PAGES]),
        .rdata (rd_data[DATA_PAGES]),
        .cfg   (cfg),
        .gcc   (global_current),
        .rowpu (row_pullup),
        .colpd (col_pulldown)
    );

    assign sync_mode = cfg.sync;
    assign pwm_freq  = cfg.pfreq;
    assign run_en    = cfg.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_mask   <= '0;
            irq_status <= '0;
        end else if (wr.en) begin
            if (wr.addr == ADR_IRQMASK) irq_mask   <= wr.data;
            if (wr.addr == ADR_IRQSTAT) irq_status <= wr.data;
        end
    end

endmodule

// File: rtl/ledbank_chk.sv
module ledbank_chk
    import ledbank_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input wr_t        wr,
    input logic       unlocked,
    input logic       lock_err,
    input logic [1:0] cur_page,
    input logic       run_en,
    input logic       cfg_clr
);

    p_key_needed_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(wr.en && wr.addr == ADR_KEY && wr.data == UNLOCK_KEY));

    p_oneshot_r3: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == ADR_PAGESEL && unlocked) |=> !unlocked);

    p_page_gate_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_page) |-> $past(unlocked));

    p_locked_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == ADR_PAGESEL && !unlocked) |=> ($stable(cur_page) && lock_err));

    p_sticky_err_r4: assert property (@(posedge clk) disable iff (rst)
        lock_err |=> lock_err);

    p_clear_run_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_clr |=> !run_en);

endmodule

bind ledbank_top ledbank_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr       (wr),
    .unlocked (unlocked),
    .lock_err (lock_err),
    .cur_page (cur_page),
    .run_en   (run_en),
    .cfg_clr  (cfg_clr)
);

// File: tb/tb_ledbank_top.sv
module tb_ledbank_top;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_start = 1'b0;
    logic            bus_valid = 1'b0;
    logic [7:0]      bus_data = '0;
    logic [3:0][7:0] rd_addr = '0;
    logic [3:0][7:0] rd_data;
    logic [1:0]      cur_page;
    logic            unlocked, lock_err, run_en;
    logic [1:0]      sync_mode;
    logic [2:0]      pwm_freq;
    logic [7:0]      global_current, row_pullup, col_pulldown, irq_mask, irq_status;

    int errors = 0;
    int checks = 0;
    int pending = 0;
    bit done = 0;

    typedef struct {
        int         pg;
        logic [7:0] a;
        logic [7:0] v;
        string      tag;
    } exp_t;
    exp_t sb [$];

    always #4 clk = ~clk;

    ledbank_top dut (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_valid(bus_valid),
        .bus_data(bus_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cur_page(cur_page), .unlocked(unlocked), .lock_err(lock_err),
        .sync_mode(sync_mode), .pwm_freq(pwm_freq), .run_en(run_en),
        .global_current(global_current), .row_pullup(row_pullup),
        .col_pulldown(col_pulldown), .irq_mask(irq_mask), .irq_status(irq_status)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // scoreboard: push expected read-back, monitor pops and compares
    task automatic expect_rd(input int pg, input logic [7:0] a, input logic [7:0] v, input string tag);
        exp_t e;
        e.pg = pg; e.a = a; e.v = v; e.tag = tag;
        sb.push_back(e);
        pending++;
        wait (pending == 0);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                rd_addr[e.pg] = e.a;
                #1;
                chk(e.tag, int'(rd_data[e.pg]), int'(e.v));
                pending--;
            end
        end
    end

    task automatic burst(input logic [7:0] a, input logic [7:0] d [$]);
        @(negedge clk);
        bus_start = 1'b1; bus_valid = 1'b0;
        @(negedge clk);
        bus_start = 1'b0; bus_valid = 1'b1; bus_data = a;
        foreach (d[i]) begin
            @(negedge clk);
            bus_data = d[i];
        end
        @(negedge clk);
        bus_valid = 1'b0;
        #1;
    endtask

    task automatic sel_page(input logic [7:0] p);
        burst(8'hFE, '{8'hC5});
        burst(8'hFD, '{p});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 page", cur_page, 0);
        chk("R1 unlocked", unlocked, 0);
        chk("R1 lock_err", lock_err, 0);
        chk("R1 run_en", run_en, 0);
        expect_rd(0, 8'h00, 8'h00, "R1 page0 read");

        // R2 auto-increment on page 0
        burst(8'h10, '{8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17, 8'h18});
        expect_rd(0, 8'h10, 8'h11, "R2 first byte");
        expect_rd(0, 8'h13, 8'h14, "R2 fourth byte");
        expect_rd(0, 8'h17, 8'h18, "R2 last byte");
        // R11 writes past page 0 end are dropped
        burst(8'h16, '{8'hA1, 8'hA2, 8'hA3});
        expect_rd(0, 8'h17, 8'hA2, "R11 last in range");
        expect_rd(0, 8'h18, 8'h00, "R11 out of range");

        // R5 wrong key, R4 refused select
        burst(8'hFE, '{8'h5A});
        chk("R5 still locked", unlocked, 0);
        burst(8'hFD, '{8'h01});
        chk("R4 page held", cur_page, 0);
        chk("R4 lock_err set", lock_err, 1);

        // R3 unlock and select page 1
        burst(8'hFE, '{8'hC5});
        chk("R3 unlocked", unlocked, 1);
        burst(8'hFD, '{8'h01});
        chk("R3 page 1", cur_page, 1);
        chk("R3 relocked", unlocked, 0);
        chk("R4 err sticky", lock_err, 1);

        // R7 PWM page end
        burst(8'hBE, '{8'h21, 8'h22, 8'h23});
        expect_rd(1, 8'hBE, 8'h21, "R7 pwm BE");
        expect_rd(1, 8'hBF, 8'h22, "R7 pwm BF");
        expect_rd(1, 8'hC0, 8'h00, "R11 pwm C0");
        expect_rd(0, 8'h10, 8'h11, "R7 page0 untouched");

        // R6 out-of-range page value
        sel_page(8'h07);
        chk("R6 page kept", cur_page, 1);
        chk("R6 relocked", unlocked, 0);

        // R9 interrupt registers on page 1
        burst(8'hF0, '{8'h3C, 8'h81});
        chk("R9 mask", irq_mask, 8'h3C);
        chk("R9 status", irq_status, 8'h81);

        // R7 breath page
        sel_page(8'h02);
        chk("R3 page 2", cur_page, 2);
        burst(8'h05, '{8'h77});
        expect_rd(2, 8'h05, 8'h77, "R7 breath write");

        // R8 function page
        sel_page(8'h03);
        burst(8'h00, '{8'hA9, 8'h40});
        burst(8'h0F, '{8'h05, 8'h06});
        chk("R8 sync", sync_mode, 2);
        chk("R8 pfreq", pwm_freq, 5);
        chk("R8 run", run_en, 1);
        chk("R8 gcc", global_current, 8'h40);
        chk("R8 rowpu", row_pullup, 8'h05);
        chk("R8 colpd", col_pulldown, 8'h06);
        expect_rd(3, 8'h00, 8'hA9, "R8 cfg read");
        expect_rd(3, 8'h02, 8'h00, "R11 fn hole");

        // R10 clear through reset register
        burst(8'h11, '{8'h00});
        chk("R10 run", run_en, 0);
        chk("R10 sync", sync_mode, 0);
        chk("R10 gcc", global_current, 0);
        chk("R10 page kept", cur_page, 3);
        chk("R10 irq kept", irq_mask, 8'h3C);
        expect_rd(0, 8'h10, 8'h00, "R10 page0 cleared");
        expect_rd(1, 8'hBE, 8'h00, "R10 pwm cleared");
        expect_rd(2, 8'h05, 8'h00, "R10 breath cleared");

        // R12 address taken with strobe; restart mid-burst
        @(negedge clk);
        bus_start = 1'b1; bus_valid = 1'b1; bus_data = 8'h01;
        @(negedge clk);
        bus_start = 1'b0; bus_data = 8'h55;
        @(negedge clk);
        bus_valid = 1'b0;
        #1;
        chk("R12 same-cycle addr", global_current, 8'h55);
        @(negedge clk);
        bus_start = 1'b1; bus_valid = 1'b1; bus_data = 8'h0F;
        @(negedge clk);
        bus_start = 1'b0; bus_data = 8'h02;
        @(negedge clk);
        bus_start = 1'b1; bus_data = 8'h10;
        @(negedge clk);
        bus_start = 1'b0; bus_data = 8'h03;
        @(negedge clk);
        bus_valid = 1'b0;
        #1;
        chk("R12 row", row_pullup, 8'h02);
        chk("R12 col", col_pulldown, 8'h03);
        chk("R12 gcc untouched", global_current, 8'h55);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule